// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial front end of a small serial EEPROM controller. When a write instruction opens a transaction, it receives a starting byte address and then a stream of data bytes. It collects them in a page buffer of `PAGE_BYTES` slots. Each accepted byte lands in the slot selected by the in-page pointer. The pointer then advances within the page only, so a long burst wraps and overwrites earlier slots of the same page. The page number never changes during a transaction.

When chip select rises, the block judges the transaction. A commit is accepted only if all of the following hold:
- the write enable latch is set;
- the write inhibit input is low;
- the rise falls on a byte boundary;
- at least one complete byte has been received.

Any other case discards the buffer and closes the transaction. An accepted commit starts a self-timed programming cycle. The sequencer walks the slots in ascending order and presents every slot written during the transaction on a valid/ready array write port. It holds `busy` high for `PROG_CYCLES` system clocks, or longer if the array stalls. When the cycle ends, it pulses `wel_clr` so that the write enable latch is cleared.

The data input stream follows valid/ready rules. A byte is taken on a cycle where `din_valid` and `din_ready` are both high. `din_ready` depends only on block state and on `cs_rise`, never on `din_valid`. The array port holds `arr_valid`, `arr_addr` and `arr_data` steady until `arr_ready` is seen, and the array may stall for any number of cycles.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy`, `wel_clr`, `arr_valid` and `din_ready` are all low.
- R2: `din_ready` is high only while a transaction is open and no programming cycle runs. A `txn_open` pulse opens a transaction in the next cycle. A `cs_rise` pulse closes it.
- R3: The address is split into a page number (upper `ADDR_W-3` bits) and a slot (low 3 bits, with the default 8-byte page). Each accepted byte advances only the slot, modulo `PAGE_BYTES`. When more than `PAGE_BYTES` bytes arrive, the last byte sent to a slot is the one programmed.
- R4: A `cs_rise` with `wr_enabled`=1, `wr_inhibit`=0, `cs_mid_byte`=0 and at least one accepted byte makes `busy` high in the next cycle.
- R5: A `cs_rise` with `wr_enabled`=0 or `wr_inhibit`=1 commits nothing. `busy` stays low, no array write occurs and `din_ready` goes low.
- R6: A `cs_rise` with `cs_mid_byte`=1, or one arriving before any byte was accepted, commits nothing.
- R7: With `arr_ready` held high, `busy` stays high for exactly `PROG_CYCLES` cycles.
- R8: Only slots written during the transaction are sent to the array, at address {page, slot}. The other bytes of the page keep their old values.
- R9: `wel_clr` is a one-cycle pulse in the first cycle in which `busy` is low after a programming cycle. Rejected commits give no pulse.
- R10: While `busy` is high, `txn_open`, data bytes and `cs_rise` have no effect. The cycle is not restarted or extended.
- R11: While `arr_valid` is high and `arr_ready` is low, the address and data are held. `busy` stays high until every written slot has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_open | input | 1 | Pulse: a write instruction and its address have been received |
| txn_addr | input | ADDR_W | Starting byte address of the transaction |
| din_valid | input | 1 | Data byte is valid |
| din_ready | output | 1 | Block can accept a data byte |
| din_data | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| cs_mid_byte | input | 1 | Qualifies `cs_rise`: a partial byte was in flight |
| wr_enabled | input | 1 | Current state of the write enable latch |
| wr_inhibit | input | 1 | High when the hardware write lock is active |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write enable latch |
| arr_valid | output | 1 | Array write request valid |
| arr_ready | input | 1 | Array accepts the write |
| arr_addr | output | ADDR_W | Array byte address |
| arr_data | output | 8 | Array write data |

## Verification
The hardest case to reach is array back-pressure that outlasts the programming timer. There the end of `busy` is decided by the drain of the slots, not by the counter. The stimulus holds `arr_ready` low for longer than `PROG_CYCLES` from the commit. It samples the held request in the middle of the stall, then releases the port and checks that `busy` ends only after the drain. A second hard case is traffic during programming. The bench injects an open, a byte and a chip-select rise while `busy` is high. It then checks the exact busy length, and that no transaction was left open afterwards.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_PROG = 1'b1
  } sq_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
// Page buffer: one storage slot per byte of a page, a used flag per slot,
// and a pointer that wraps inside the page. PAGE_BYTES must be a power of two.
module pgw_page_buf
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [ADDR_W-1:0]                 load_addr,
  input  logic                              wr_en,
  input  byte_t                             wr_data,
  input  logic                              clear,
  input  logic [$clog2(PAGE_BYTES)-1:0]     rd_slot,
  output byte_t                             rd_data,
  output logic [PAGE_BYTES-1:0]             used,
  output logic                              any_used,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_no
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0] ptr_q;
  logic [PAGE_W-1:0] page_q;
  byte_t             slot_bytes [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (load) begin
      ptr_q  <= load_addr[SLOT_W-1:0];
      page_q <= load_addr[ADDR_W-1:SLOT_W];
    end else if (wr_en) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    byte_t byte_q;
    logic  used_q;
    logic  hit;
    assign hit = wr_en && (ptr_q == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        used_q <= 1'b0;
      end else begin
        if (hit) byte_q <= wr_data;
        if (load || clear) used_q <= 1'b0;
        else if (hit)      used_q <= 1'b1;
      end
    end

    assign slot_bytes[g] = byte_q;
    assign used[g]       = used_q;
  end

  assign rd_data  = slot_bytes[rd_slot];
  assign any_used = |used;
  assign page_no  = page_q;
endmodule

// File: rtl/pgw_commit_gate.sv
// Tracks the open transaction and judges the chip-select rise.
module pgw_commit_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic cs_rise,
  input  logic busy,
  input  logic wr_enabled,
  input  logic wr_inhibit,
  input  logic mid_byte,
  input  logic any_used,
  output logic open_ok,
  output logic live,
  output logic go,
  output logic drop
);
  logic live_q;
  logic close_evt;

  assign open_ok   = open_req && !busy;
  assign close_evt = cs_rise && live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live_q <= 1'b0;
    else if (open_ok)   live_q <= 1'b1;
    else if (close_evt) live_q <= 1'b0;
  end

  assign live = live_q;
  assign go   = close_evt && !busy && wr_enabled && !wr_inhibit
                && !mid_byte && any_used;
  assign drop = close_evt && !go;
endmodule

// File: rtl/pgw_prog_seq.sv
// Self-timed programming cycle: drains the used slots in ascending order
// over a valid/ready port while a timer runs PROG_CYCLES clocks.
module pgw_prog_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [PAGE_BYTES-1:0]         used,
  output logic [$clog2(PAGE_BYTES)-1:0] slot,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic                          busy,
  output logic                          done,
  output logic                          wel_clr
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int IDX_W  = SLOT_W + 1;
  localparam int TMR_W  = $clog2(PROG_CYCLES + 1);

  sq_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TMR_W-1:0] tmr_q;
  logic             wel_q;
  logic             drained;
  logic             cur_used;
  logic             advance;

  assign drained  = (idx_q == IDX_W'(PAGE_BYTES));
  assign slot     = idx_q[SLOT_W-1:0];
  assign cur_used = !drained && used[slot];
  assign busy     = (state_q == SQ_PROG);
  assign req_valid = busy && cur_used;
  assign advance  = busy && !drained && (!cur_used || req_ready);
  assign done     = busy && drained && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
      wel_q   <= 1'b0;
    end else begin
      wel_q <= done;
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_PROG;
          idx_q   <= '0;
          tmr_q   <= TMR_W'(PROG_CYCLES - 1);
        end
        SQ_PROG: begin
          if (advance)       idx_q   <= idx_q + 1'b1;
          if (tmr_q != '0)   tmr_q   <= tmr_q - 1'b1;
          if (done)          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign wel_clr = wel_q;
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_open,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  input  logic              cs_rise,
  input  logic              cs_mid_byte,
  input  logic              wr_enabled,
  input  logic              wr_inhibit,
  output logic              busy,
  output logic              wel_clr,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic                  open_ok, live, go, drop, done, any_used, accept;
  logic [PAGE_BYTES-1:0] used;
  logic [SLOT_W-1:0]     slot;
  logic [PAGE_W-1:0]     page_no;
  byte_t                 rd_data;

  assign din_ready = live && !busy && !cs_rise;
  assign accept    = din_valid && din_ready;

  pgw_commit_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_req   (txn_open),
    .cs_rise    (cs_rise),
    .busy       (busy),
    .wr_enabled (wr_enabled),
    .wr_inhibit (wr_inhibit),
    .mid_byte   (cs_mid_byte),
    .any_used   (any_used),
    .open_ok    (open_ok),
    .live       (live),
    .go         (go),
    .drop       (drop)
  );

  pgw_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (open_ok),
    .load_addr (txn_addr),
    .wr_en     (accept),
    .wr_data   (din_data),
    .clear     (drop || done),
    .rd_slot   (slot),
    .rd_data   (rd_data),
    .used      (used),
    .any_used  (any_used),
    .page_no   (page_no)
  );

  pgw_prog_seq #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .used      (used),
    .slot      (slot),
    .req_valid (arr_valid),
    .req_ready (arr_ready),
    .busy      (busy),
    .done      (done),
    .wel_clr   (wel_clr)
  );

  assign arr_addr = {page_no, slot};
  assign arr_data = rd_data;
endmodule

// File: rtl/page_write_engine_chk.sv
module page_write_engine_chk #(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wel_clr,
  input logic              din_ready,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [7:0]        arr_data,
  input logic              cs_rise,
  input logic              wr_enabled,
  input logic              wr_inhibit
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  a_r2_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !din_ready);

  a_r5_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && (!wr_enabled || wr_inhibit)) |=> !busy);

  a_r7_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run >= PROG_CYCLES));

  a_r8_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> busy);

  a_r9_pulse_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wel_clr);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(arr_data)));
endmodule

bind page_write_engine page_write_engine_chk #(
  .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel_clr(wel_clr),
  .din_ready(din_ready), .arr_valid(arr_valid), .arr_ready(arr_ready),
  .arr_addr(arr_addr), .arr_data(arr_data), .cs_rise(cs_rise),
  .wr_enabled(wr_enabled), .wr_inhibit(wr_inhibit)
);

// File: tb/page_write_engine_tb.sv
module page_write_engine_tb;
  localparam int AW = 9;
  localparam int PB = 8;
  localparam int PC = 40;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txn_open = 1'b0;
  logic [AW-1:0] txn_addr = '0;
  logic          din_valid = 1'b0;
  logic          din_ready;
  logic [7:0]    din_data = '0;
  logic          cs_rise = 1'b0;
  logic          cs_mid_byte = 1'b0;
  logic          wr_enabled = 1'b0;
  logic          wr_inhibit = 1'b0;
  logic          busy, wel_clr, arr_valid;
  logic          arr_ready = 1'b1;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_data;

  logic [7:0] mem [MEM];
  logic [7:0] exp_mem [MEM];
  logic [7:0] pay [16];
  int wr_cnt;
  int n_chk = 0;
  int n_fail = 0;
  int bcnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  page_write_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .txn_open(txn_open), .txn_addr(txn_addr),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .cs_rise(cs_rise), .cs_mid_byte(cs_mid_byte), .wr_enabled(wr_enabled),
    .wr_inhibit(wr_inhibit), .busy(busy), .wel_clr(wel_clr),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data)
  );

  // Array model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM; i++) mem[i] <= 8'hFF;
      wr_cnt <= 0;
    end else if (arr_valid && arr_ready) begin
      mem[arr_addr] <= arr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (busy) bcnt++;
  endtask

  task automatic pulse_open(input logic [AW-1:0] a);
    txn_addr = a; txn_open = 1'b1;
    tick();
    txn_open = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    din_data = d; din_valid = 1'b1;
    tick();
    din_valid = 1'b0;
  endtask

  task automatic raise_cs(input logic mid);
    cs_rise = 1'b1; cs_mid_byte = mid;
    tick();
    cs_rise = 1'b0; cs_mid_byte = 1'b0;
  endtask

  task automatic model(input logic [AW-1:0] a, input int n);
    logic [AW-1:0] p = a;
    for (int i = 0; i < n; i++) begin
      exp_mem[p] = pay[i];
      p[2:0] = p[2:0] + 3'd1;
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEM; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic finish_cycle(input int min_len, input int max_len, input string req);
    while (busy) tick();
    chk(bcnt >= min_len && bcnt <= max_len, {req, " busy length"}, bcnt, min_len);
    chk(wel_clr === 1'b1, "R9 pulse after busy", wel_clr, 1);
    tick();
    chk(wel_clr === 1'b0, "R9 single pulse", wel_clr, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                          input logic en, input logic inh, input logic mid,
                          input logic exp_go, input string req);
    int w0 = wr_cnt;
    int slots = (n > PB) ? PB : n;
    wr_enabled = en; wr_inhibit = inh;
    pulse_open(a);
    chk(din_ready === 1'b1, "R2 ready while open", din_ready, 1);
    for (int i = 0; i < n; i++) begin
      pay[i] = seed + 8'(i * 8'h13);
      push(pay[i]);
    end
    bcnt = 0;
    raise_cs(mid);
    chk(busy === exp_go, {req, " commit decision"}, busy, exp_go);
    if (exp_go) begin
      model(a, n);
      finish_cycle(PC, PC, "R7");
      chk(wr_cnt - w0 == slots, "R8 written slot count", wr_cnt - w0, slots);
    end else begin
      chk(din_ready === 1'b0, {req, " transaction closed"}, din_ready, 0);
      repeat (3) tick();
      chk(wr_cnt == w0 && wel_clr === 1'b0, {req, " no write, no pulse"}, wr_cnt - w0, 0);
    end
    compare_mem({req, " array contents"});
  endtask

  // Scenario: traffic during programming is ignored (R10)
  task automatic t_busy_ignore();
    int w0 = wr_cnt;
    wr_enabled = 1'b1; wr_inhibit = 1'b0;
    pulse_open(9'h0C8);
    for (int i = 0; i < 3; i++) begin pay[i] = 8'h70 + 8'(i); push(pay[i]); end
    bcnt = 0;
    raise_cs(1'b0);
    model(9'h0C8, 3);
    pulse_open(9'h040);
    chk(din_ready === 1'b0, "R10 no ready during busy", din_ready, 0);
    push(8'hAB);
    raise_cs(1'b0);
    finish_cycle(PC, PC, "R10");
    chk(din_ready === 1'b0, "R10 open during busy ignored", din_ready, 1'b0);
    chk(wr_cnt - w0 == 3, "R10 write count", wr_cnt - w0, 3);
    compare_mem("R10 array contents");
  endtask

  // Scenario: array stalls longer than the timer (R11)
  task automatic t_backpressure();
    wr_enabled = 1'b1; wr_inhibit = 1'b0;
    arr_ready = 1'b0;
    pulse_open(9'h100);
    pay[0] = 8'h5A; pay[1] = 8'hC3;
    push(pay[0]); push(pay[1]);
    bcnt = 0;
    raise_cs(1'b0);
    repeat (30) tick();
    chk(arr_valid === 1'b1 && arr_addr == 9'h100 && arr_data == 8'h5A,
        "R11 request held", int'(arr_addr), 9'h100);
    repeat (30) tick();
    chk(busy === 1'b1, "R11 busy extended by stall", busy, 1);
    arr_ready = 1'b1;
    model(9'h100, 2);
    finish_cycle(PC + 1, 61 + PB + 2, "R11");
    compare_mem("R11 array contents");
  endtask

  initial begin
    for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && wel_clr === 1'b0 && arr_valid === 1'b0 && din_ready === 1'b0,
        "R1 reset state", {busy, wel_clr, arr_valid, din_ready}, 0);
    // R4, R7, R8: plain write of three bytes starting at slot 5
    do_write(9'h1A5, 3, 8'h21, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    // R3: ten bytes from slot 6 wrap and overwrite slots 6 and 7
    do_write(9'h0F6, 10, 8'h90, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    // R5: latch clear, then hardware lock
    do_write(9'h010, 2, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R5 latch clear");
    do_write(9'h018, 2, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, "R5 lock active");
    // R6: rise mid-byte, and rise with no byte
    do_write(9'h020, 2, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0, "R6 mid byte");
    do_write(9'h028, 0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, "R6 no byte");
    // R8: a full page written exactly once from slot 0
    do_write(9'h1F8, 8, 8'hE0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    t_busy_ignore();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule